// File: doc/BRIEF.md
# Thread Criticality Accumulator

This block keeps one running criticality sum for each of a set of hardware thread contexts. Every context can raise an activate pulse when its thread begins useful work, and a deactivate pulse when the thread starts to spin-wait or is scheduled out. A timer measures the cycles since the last event that changed the active set. When such an event is handled, the elapsed time is divided by the number of contexts that were active during the interval, and the integer quotient is added to the sum of each of those contexts. A thread that runs while the others wait therefore gains criticality fastest.

Events raised in the same cycle are captured together and then handled one at a time, lowest context index first. The division is serial, and a busy output tells the event sources that new events will not be sampled. Software can clear all sums at the start of a scheduling slice. It can also read any sum and overwrite any sum, so that it can save and restore per-thread state across context switches.

Top module: `crit_accum`

## Requirements
- R1: After reset all sums read zero, no context is active, the active count is zero and busy is low.
- R2: An activate on an inactive context sets its bit in `active` and raises `nactive` by one. A deactivate on an active context clears the bit and lowers `nactive` by one. Bit i of every mask is context i.
- R3: An activate on a context that is already active, or a deactivate on one that is already inactive, changes no active bit, no count and no sum. It also does not restart the interval timer.
- R4: When a state-changing event is handled with c > 0 active contexts, floor(T / c) is added to the sum of every context that was active. T is the number of clock edges since the previous state-changing event was handled. Inactive sums are unchanged.
- R5: A state-changing event handled while the active count is zero adds nothing to any sum, but it does restart the interval timer.
- R6: Events captured in the same cycle are handled in ascending context order. Each one sees the active set that the one before it left.
- R7: Events are sampled only at an edge where busy is low. The first captured event is handled one edge later. An accumulating event occupies TW+2 edges and any other event occupies one. Busy stays high until the last captured event is finished, and events presented while busy is high have no effect.
- R8: A one-cycle pulse on `slice_clr` zeroes every sum at the next edge and leaves the active bits and the count unchanged.
- R9: With `wr_en` high, `wr_data` is loaded into the sum selected by `wr_idx` at the edge. `rd_data` always shows the sum selected by `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_act | input | NCTX | Per-context activate pulses |
| ev_deact | input | NCTX | Per-context deactivate pulses |
| busy | output | 1 | Events not sampled while high |
| active | output | NCTX | Current active bit of each context |
| nactive | output | $clog2(NCTX+1) | Number of active contexts |
| slice_clr | input | 1 | Clear all sums; beats a write in the same cycle |
| wr_en | input | 1 | Load one sum |
| wr_idx | input | $clog2(NCTX) | Context to load |
| wr_data | input | CW | Value to load |
| rd_idx | input | $clog2(NCTX) | Context to read |
| rd_data | output | CW | Sum of the selected context |

## Verification
The properties assume several things about the inputs. No context raises activate and deactivate in the same cycle. Sources respect busy except in the one deliberate case. No write or clear coincides with the edge that adds the quotients, and intervals stay short enough that the timer never saturates. The stimulus drives events one cycle at a time on falling edges and waits for busy to fall before it sends more. It keeps the gaps between events to a few cycles, and it writes or clears only while the block is idle. A single intrusion during a divide checks that events presented while busy have no effect.

// File: rtl/crit_accum.sv
module crit_accum #(
  parameter int NCTX = 16,
  parameter int CW   = 64,
  parameter int TW   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCTX-1:0]           ev_act,
  input  logic [NCTX-1:0]           ev_deact,
  output logic                      busy,
  output logic [NCTX-1:0]           active,
  output logic [$clog2(NCTX+1)-1:0] nactive,
  input  logic                      slice_clr,
  input  logic                      wr_en,
  input  logic [$clog2(NCTX)-1:0]   wr_idx,
  input  logic [CW-1:0]             wr_data,
  input  logic [$clog2(NCTX)-1:0]   rd_idx,
  output logic [CW-1:0]             rd_data
);
  localparam int IW = $clog2(NCTX);
  localparam int NW = $clog2(NCTX+1);
  localparam int SW = $clog2(TW+1);

  logic [NCTX-1:0]         pend_q, dir_q, act_q;
  logic [NW-1:0]           nact_q, dvs_q, rem_q;
  logic [TW-1:0]           tmr_q, quo_q;
  logic                    div_run_q, seldir_q;
  logic [SW-1:0]           step_q;
  logic [IW-1:0]           sel_q;
  logic [NCTX-1:0][CW-1:0] cnt_q;

  logic          pick_v, pick_dir, eff, do_pick, start_div, direct, add_now, ge;
  logic [IW-1:0] pick_i;
  logic [NW:0]   trial;

  always_comb begin
    pick_v = 1'b0;
    pick_i = '0;
    for (int i = NCTX-1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_v = 1'b1;
        pick_i = IW'(i);
      end
    end
  end

  assign pick_dir  = dir_q[pick_i];
  assign eff       = pick_dir != act_q[pick_i];
  assign do_pick   = pick_v && !div_run_q;
  assign start_div = do_pick && eff && (nact_q != '0);
  assign direct    = do_pick && eff && (nact_q == '0);
  assign add_now   = div_run_q && (step_q == SW'(TW));
  assign busy      = (|pend_q) || div_run_q;
  assign trial     = {rem_q, quo_q[TW-1]};
  assign ge        = trial >= {1'b0, dvs_q};

  assign active  = act_q;
  assign nactive = nact_q;
  assign rd_data = cnt_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      dir_q     <= '0;
      act_q     <= '0;
      nact_q    <= '0;
      tmr_q     <= '0;
      div_run_q <= 1'b0;
      step_q    <= '0;
      quo_q     <= '0;
      rem_q     <= '0;
      dvs_q     <= '0;
      sel_q     <= '0;
      seldir_q  <= 1'b0;
    end else begin
      if (start_div || direct)
        tmr_q <= TW'(1);
      else if (tmr_q != '1)
        tmr_q <= tmr_q + TW'(1);

      if (!busy) begin
        pend_q <= ev_act | ev_deact;
        dir_q  <= ev_act;
      end else if (do_pick) begin
        pend_q[pick_i] <= 1'b0;
      end

      if (start_div) begin
        div_run_q <= 1'b1;
        step_q    <= '0;
        quo_q     <= tmr_q;
        rem_q     <= '0;
        dvs_q     <= nact_q;
        sel_q     <= pick_i;
        seldir_q  <= pick_dir;
      end else if (add_now) begin
        div_run_q <= 1'b0;
      end else if (div_run_q) begin
        step_q <= step_q + SW'(1);
        rem_q  <= ge ? NW'(trial - {1'b0, dvs_q}) : trial[NW-1:0];
        quo_q  <= {quo_q[TW-2:0], ge};
      end

      if (direct) begin
        act_q[pick_i] <= pick_dir;
        nact_q        <= pick_dir ? nact_q + NW'(1) : nact_q - NW'(1);
      end else if (add_now) begin
        act_q[sel_q] <= seldir_q;
        nact_q       <= seldir_q ? nact_q + NW'(1) : nact_q - NW'(1);
      end
    end
  end

  for (genvar g = 0; g < NCTX; g++) begin : g_sum
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[g] <= '0;
      else if (slice_clr)
        cnt_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        cnt_q[g] <= wr_data;
      else if (add_now && act_q[g])
        cnt_q[g] <= cnt_q[g] + CW'(quo_q);
    end
  end
endmodule

// File: rtl/crit_accum_chk.sv
module crit_accum_chk #(
  parameter int NCTX = 16,
  parameter int CW   = 64,
  parameter int NW   = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      busy,
  input logic [NCTX-1:0]           ev_act,
  input logic [NCTX-1:0]           ev_deact,
  input logic [NCTX-1:0]           active,
  input logic [NW-1:0]             nactive,
  input logic                      slice_clr,
  input logic                      wr_en,
  input logic [NCTX-1:0][CW-1:0]   cnt
);
  assert_count_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(nactive) == $countones(active));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nactive == $past(nactive)) || (nactive == $past(nactive) + NW'(1))
             || ($past(nactive) == nactive + NW'(1)));

  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ev_act == '0 && ev_deact == '0) |=> !busy);

  assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slice_clr |=> cnt == '0);

  assert_clear_keeps_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_clr && !busy && ev_act == '0 && ev_deact == '0) |=> $stable(active));

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    assert_inactive_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active[i] && !wr_en && !slice_clr) |=> cnt[i] == $past(cnt[i]));

    assert_sum_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !slice_clr) |=> cnt[i] >= $past(cnt[i]));
  end
endmodule

bind crit_accum crit_accum_chk #(.NCTX(NCTX), .CW(CW), .NW($clog2(NCTX+1))) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ev_act(ev_act), .ev_deact(ev_deact),
  .active(active), .nactive(nactive), .slice_clr(slice_clr), .wr_en(wr_en), .cnt(cnt_q)
);

// File: tb/crit_accum_tb_top.sv
module crit_accum_tb_top;
  localparam int NCTX = 4;
  localparam int CW   = 64;
  localparam int TW   = 16;
  localparam int NV   = 14;

  // each entry: activate mask, deactivate mask, idle gap
  localparam logic [11:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 4'd3},
    {4'b0010, 4'b0000, 4'd5},
    {4'b1100, 4'b0000, 4'd2},
    {4'b0000, 4'b0010, 4'd7},
    {4'b0001, 4'b0000, 4'd4},
    {4'b0000, 4'b1000, 4'd1},
    {4'b0000, 4'b0101, 4'd3},
    {4'b0000, 4'b0001, 4'd6},
    {4'b1111, 4'b0000, 4'd9},
    {4'b0000, 4'b1111, 4'd2},
    {4'b0100, 4'b0000, 4'd6},
    {4'b0000, 4'b0100, 4'd0},
    {4'b0011, 4'b0000, 4'd5},
    {4'b0000, 4'b0001, 4'd3}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCTX-1:0] ev_act = '0, ev_deact = '0;
  logic            busy;
  logic [NCTX-1:0] active;
  logic [2:0]      nactive;
  logic            slice_clr = 1'b0, wr_en = 1'b0;
  logic [1:0]      wr_idx = '0, rd_idx = '0;
  logic [CW-1:0]   wr_data = '0, rd_data;

  int total = 0, bad = 0;
  longint cyc = 0;
  longint unsigned m_cnt [NCTX];
  logic [NCTX-1:0] m_act;
  int m_n;
  longint m_last;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  crit_accum #(.NCTX(NCTX), .CW(CW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_act(ev_act), .ev_deact(ev_deact), .busy(busy),
    .active(active), .nactive(nactive), .slice_clr(slice_clr), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic chk_sums(input string req);
    for (int k = 0; k < NCTX; k++) begin
      rd_idx = 2'(k);
      #1;
      chk(rd_data, m_cnt[k], req);
    end
  endtask

  task automatic chk_state(input string req);
    chk(64'(active), 64'(m_act), {req, " active"});
    chk(64'(nactive), 64'(m_n), {req, " nactive"});
  endtask

  task automatic post(input logic [NCTX-1:0] a, input logic [NCTX-1:0] d,
                      input logic [NCTX-1:0] intr);
    longint s, p, nf;
    logic dirk;
    @(negedge clk);
    ev_act = a;
    ev_deact = d;
    s = cyc + 1;
    nf = s + 1;
    for (int k = 0; k < NCTX; k++) begin
      if (a[k] || d[k]) begin
        p = nf;
        dirk = a[k];
        if (dirk == m_act[k]) begin
          nf = p + 1;
        end else if (m_n == 0) begin
          m_last = p;
          m_act[k] = dirk;
          m_n = m_n + (dirk ? 1 : -1);
          nf = p + 1;
        end else begin
          for (int j = 0; j < NCTX; j++)
            if (m_act[j]) m_cnt[j] += longint'(unsigned'((p - m_last) / m_n));
          m_last = p;
          m_act[k] = dirk;
          m_n = m_n + (dirk ? 1 : -1);
          nf = p + TW + 2;
        end
      end
    end
    @(negedge clk);
    ev_act = '0;
    ev_deact = '0;
    if (intr != '0) begin
      @(negedge clk);
      ev_act = intr;
      @(negedge clk);
      ev_act = '0;
    end
    while (cyc < nf - 2) @(negedge clk);
    chk(64'(busy), 64'd1, "R7 busy before finish");
    @(negedge clk);
    chk(64'(busy), 64'd0, "R7 busy after finish");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCTX; k++) m_cnt[k] = 0;
    m_act = '0;
    m_n = 0;
    m_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(64'(busy), 64'd0, "R1 busy");
    chk_state("R1");
    chk_sums("R1 sums");

    // R2 R3 R4 R5 R6 vector walk
    for (int v = 0; v < NV; v++) begin
      post(VEC[v][11:8], VEC[v][7:4], '0);
      chk_state("R2 R3 R6 state");
      chk_sums("R4 R5 R6 sums");
      repeat (VEC[v][3:0]) @(negedge clk);
    end

    // R3 redundant activate does not restart the timer
    post(4'b0001, 4'b0000, '0);
    repeat (4) @(negedge clk);
    post(4'b0001, 4'b0000, '0);
    post(4'b0100, 4'b0000, '0);
    chk_state("R3 redundant");
    chk_sums("R3 timer kept");

    // R7 intrusion while busy has no effect
    post(4'b0000, 4'b0100, 4'b1000);
    chk_state("R7 intrusion");
    chk_sums("R7 intrusion sums");

    // R8 slice clear
    @(negedge clk);
    slice_clr = 1'b1;
    @(negedge clk);
    slice_clr = 1'b0;
    for (int k = 0; k < NCTX; k++) m_cnt[k] = 0;
    chk_sums("R8 cleared");
    chk_state("R8 set kept");
    repeat (3) @(negedge clk);
    post(4'b0010, 4'b0000, '0);
    chk_sums("R8 resumes");

    // R9 write and read back
    @(negedge clk);
    wr_en = 1'b1;
    wr_idx = 2'd2;
    wr_data = 64'h0000_0001_0000_03E8;
    @(negedge clk);
    wr_en = 1'b0;
    m_cnt[2] = 64'h0000_0001_0000_03E8;
    chk_sums("R9 write");
    repeat (2) @(negedge clk);
    post(4'b0100, 4'b0000, '0);
    repeat (5) @(negedge clk);
    post(4'b0000, 4'b0011, '0);
    chk_sums("R9 restored sum accumulates");
    chk_state("R9 state");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule